// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block is a passive observer of a two-bank SDRAM command bus. It samples the chip-select, row-strobe, column-strobe and write-enable lines, the bank-select bit and the address bit 10 on every rising clock edge. From these it decodes the command in flight. It keeps a model of each bank (idle or open) and counts elapsed clocks per bank and globally. It reports any command that breaks a bank-state rule or a minimum-spacing rule.

When a rule is broken, a one-cycle error pulse is raised together with a 4-bit error code and the bank involved. A sticky flag latches until a synchronous clear. The monitor never stalls or drives the bus, so it has no valid/ready handshake. The sampled pins are accepted on every clock without back-pressure, and the report pins are plain status.

Spacing limits, burst length, mode-register quiet time and the refresh deadline are parameters. Their defaults suit a 100 MHz part: RCD 2, RP 2, RAS 5, RC 7, RRD 2, quiet 2, burst 4, refresh 1562.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from {cs_n,ras_n,cas_n,we_n}:
  - 0000 mode set
  - 0001 refresh
  - 0010 precharge
  - 0011 activate
  - 0100 write
  - 0101 read
  - 0110 burst stop
  - 0111 no-op

  Any cycle with cs_n high is deselected and, like a no-op, never raises an error.
- R2: A mode set or refresh while either bank is open gives code 1, bank 0.
- R3: Within T_MRD (2) clocks after a mode set, any command other than no-op or deselect gives code 2, bank 0.
- R4: A read or write to an idle bank gives code 3. An activate to an open bank gives code 4. Both report the addressed bank.
- R5: A precharge with a10 high closes both banks whatever ba_i is. With a10 low, only bank ba_i is closed.
- R6: A read or write fewer than T_RCD (2) clocks after an activate of the same bank gives code 5.
- R7: An activate fewer than T_RP (2) clocks after that bank was closed gives code 6. A precharge fewer than T_RAS (5) clocks after the bank's activate gives code 7.
- R8: An activate fewer than T_RC (7) clocks after the same bank's activate gives code 8. One fewer than T_RRD (2) clocks after the other bank's activate gives code 9.
- R9: A read or write with a10 high starts an auto-precharge burst. Any read or write in the following BURST_LEN-1 clocks gives code 10. The bank closes when the burst ends, and its precharge spacing counts from that point.
- R10: If REF_LIMIT clocks pass after a refresh (or after reset) with no new refresh, code 11 (bank 0) is raised once.
- R11: err_valid_o pulses in the clock after the edge that sampled the offending command. err_code_o and err_bank_o hold the last error. err_flag_o stays high until clr_i. An error in the same clock as clr_i wins over the clear.
- R12: When several rules are broken at once, the lowest code is reported.
- R13: After reset, both banks are idle and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clears sticky flag, code and bank |
| cs_n | input | 1 | Sampled chip select, low active |
| ras_n | input | 1 | Sampled row strobe, low active |
| cas_n | input | 1 | Sampled column strobe, low active |
| we_n | input | 1 | Sampled write enable, low active |
| ba_i | input | 1 | Bank select |
| a10_i | input | 1 | Address bit 10 (all-bank / auto-precharge) |
| err_valid_o | output | 1 | One-cycle error pulse |
| err_flag_o | output | 1 | Sticky error flag |
| err_code_o | output | 4 | Code of the last error |
| err_bank_o | output | 1 | Bank of the last error |

## Verification
Every report is registered once, so each result is due exactly one clock after the edge that sampled the command. The bench changes the pins on the falling edge and reads the outputs on the next falling edge, before driving the next command. Spacing expectations are worked out in clocks from the table row that opened or closed each bank. The refresh deadline is checked by counting no-op cycles from a refresh: the pulse must come on the REF_LIMIT-th one and not before.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  localparam int NB   = 2;
  localparam int BA_W = 1;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111,
    CMD_DES = 4'b1000
  } cmd_e;

  typedef enum logic [3:0] {
    ERR_NONE      = 4'd0,
    ERR_CFG_BUSY  = 4'd1,
    ERR_MRS_QUIET = 4'd2,
    ERR_IDLE_RW   = 4'd3,
    ERR_ACT_OPEN  = 4'd4,
    ERR_RCD       = 4'd5,
    ERR_RP        = 4'd6,
    ERR_RAS       = 4'd7,
    ERR_RC        = 4'd8,
    ERR_RRD       = 4'd9,
    ERR_AP_BUSY   = 4'd10,
    ERR_REF_LATE  = 4'd11
  } err_e;
endpackage

// File: rtl/sdram_mon_decode.sv
module sdram_mon_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd_o
);
  // deselect masks the strobes entirely (R1)
  always_comb begin
    if (cs_n) cmd_o = CMD_DES;
    else      cmd_o = cmd_e'({1'b0, ras_n, cas_n, we_n});
  end
endmodule

// File: rtl/sdram_mon_bank.sv
module sdram_mon_bank #(
  parameter int AGE_MAX   = 7,
  parameter int AGE_W     = 3,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             rwap_i,
  output logic             open_o,
  output logic             ap_busy_o,
  output logic [AGE_W-1:0] act_age_o,
  output logic [AGE_W-1:0] pre_age_o
);
  localparam int AP_W = $clog2(BURST_LEN + 1);
  localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(AGE_MAX);

  logic [AP_W-1:0] ap_left;
  logic            ap_close;

  // burst end closes the bank; a length-1 burst closes at once
  generate
    if (BURST_LEN > 1) begin : g_long
      assign ap_close = (ap_left == AP_W'(1));
    end else begin : g_single
      assign ap_close = rwap_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o    <= 1'b0;
      act_age_o <= AGE_TOP;
      pre_age_o <= AGE_TOP;
      ap_left   <= '0;
    end else begin
      if (act_i)                  act_age_o <= AGE_W'(1);
      else if (act_age_o != AGE_TOP) act_age_o <= act_age_o + AGE_W'(1);

      if (pre_i || ap_close)      pre_age_o <= AGE_W'(1);
      else if (pre_age_o != AGE_TOP) pre_age_o <= pre_age_o + AGE_W'(1);

      if (rwap_i && BURST_LEN > 1) ap_left <= AP_W'(BURST_LEN - 1);
      else if (ap_left != '0)      ap_left <= ap_left - AP_W'(1);

      if (act_i)                  open_o <= 1'b1;
      else if (pre_i || ap_close) open_o <= 1'b0;
    end
  end

  assign ap_busy_o = (ap_left != '0);

  p_open_after_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> open_o);
  p_close_on_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && !act_i) |=> !open_o);
  p_ap_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rwap_i && BURST_LEN > 1) |=> ap_busy_o);
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RAS     = 5,
  parameter int T_RC      = 7,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4,
  parameter int REF_LIMIT = 1562
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       ba_i,
  input  logic       a10_i,
  output logic       err_valid_o,
  output logic       err_flag_o,
  output logic [3:0] err_code_o,
  output logic       err_bank_o
);
  localparam int M1 = (T_RC > T_RAS) ? T_RC : T_RAS;
  localparam int M2 = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int AGE_MAX = (M3 > T_RRD) ? M3 : T_RRD;
  localparam int AGE_W = $clog2(AGE_MAX + 1);
  localparam int MRD_W = $clog2(T_MRD + 1);
  localparam int REF_W = $clog2(REF_LIMIT + 2);
  localparam logic [AGE_W-1:0] L_RCD = AGE_W'(T_RCD);
  localparam logic [AGE_W-1:0] L_RP  = AGE_W'(T_RP);
  localparam logic [AGE_W-1:0] L_RAS = AGE_W'(T_RAS);
  localparam logic [AGE_W-1:0] L_RC  = AGE_W'(T_RC);
  localparam logic [AGE_W-1:0] L_RRD = AGE_W'(T_RRD);
  localparam logic [REF_W-1:0] L_REF = REF_W'(REF_LIMIT);

  cmd_e cmd;
  sdram_mon_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd_o(cmd)
  );

  logic is_act, is_pre, is_rw, is_mrs, is_ref, is_quiet;
  assign is_act   = (cmd == CMD_ACT);
  assign is_pre   = (cmd == CMD_PRE);
  assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign is_mrs   = (cmd == CMD_MRS);
  assign is_ref   = (cmd == CMD_REF);
  assign is_quiet = (cmd == CMD_NOP) || (cmd == CMD_DES);

  logic [NB-1:0]    bsel, act_hit, pre_hit, rwap_hit, bopen, ap_busy;
  logic [NB-1:0]    ras_bad, rrd_young;
  logic [AGE_W-1:0] act_age [NB];
  logic [AGE_W-1:0] pre_age [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bsel[b]     = (ba_i == BA_W'(b));
    assign act_hit[b]  = is_act && bsel[b];
    assign pre_hit[b]  = is_pre && (a10_i || bsel[b]);
    assign rwap_hit[b] = is_rw && a10_i && bsel[b];
    assign ras_bad[b]  = pre_hit[b] && bopen[b] && (act_age[b] < L_RAS);
    assign rrd_young[b] = !bsel[b] && (act_age[b] < L_RRD);

    sdram_mon_bank #(
      .AGE_MAX(AGE_MAX), .AGE_W(AGE_W), .BURST_LEN(BURST_LEN)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_i(act_hit[b]), .pre_i(pre_hit[b]), .rwap_i(rwap_hit[b]),
      .open_o(bopen[b]), .ap_busy_o(ap_busy[b]),
      .act_age_o(act_age[b]), .pre_age_o(pre_age[b])
    );
  end

  logic [MRD_W-1:0] mrs_left;
  logic [REF_W-1:0] ref_age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrs_left <= '0;
      ref_age  <= '0;
    end else begin
      if (is_mrs)               mrs_left <= MRD_W'(T_MRD);
      else if (mrs_left != '0)  mrs_left <= mrs_left - MRD_W'(1);
      if (is_ref)               ref_age <= REF_W'(1);
      else if (ref_age <= L_REF) ref_age <= ref_age + REF_W'(1);
    end
  end

  // fixed-priority rule evaluation: lowest code wins (R12)
  err_e          vcode;
  logic [BA_W-1:0] vbank, ras_bank;

  always_comb begin
    ras_bank = ba_i;
    for (int b = NB - 1; b >= 0; b--)
      if (ras_bad[b]) ras_bank = BA_W'(b);
  end

  always_comb begin
    vcode = ERR_NONE;
    vbank = ba_i;
    if ((is_mrs || is_ref) && |bopen) begin
      vcode = ERR_CFG_BUSY;  vbank = '0;
    end else if (mrs_left != '0 && !is_quiet) begin
      vcode = ERR_MRS_QUIET; vbank = '0;
    end else if (is_rw && !bopen[ba_i]) begin
      vcode = ERR_IDLE_RW;
    end else if (is_act && bopen[ba_i]) begin
      vcode = ERR_ACT_OPEN;
    end else if (is_rw && act_age[ba_i] < L_RCD) begin
      vcode = ERR_RCD;
    end else if (is_act && pre_age[ba_i] < L_RP) begin
      vcode = ERR_RP;
    end else if (|ras_bad) begin
      vcode = ERR_RAS;       vbank = ras_bank;
    end else if (is_act && act_age[ba_i] < L_RC) begin
      vcode = ERR_RC;
    end else if (is_act && |rrd_young) begin
      vcode = ERR_RRD;
    end else if (is_rw && |ap_busy) begin
      vcode = ERR_AP_BUSY;
    end else if (ref_age == L_REF && !is_ref) begin
      vcode = ERR_REF_LATE;  vbank = '0;
    end
  end

  logic viol;
  assign viol = (vcode != ERR_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid_o <= 1'b0;
      err_flag_o  <= 1'b0;
      err_code_o  <= '0;
      err_bank_o  <= 1'b0;
    end else begin
      err_valid_o <= viol;
      if (viol) begin
        err_flag_o <= 1'b1;
        err_code_o <= vcode;
        err_bank_o <= vbank;
      end else if (clr_i) begin
        err_flag_o <= 1'b0;
        err_code_o <= '0;
        err_bank_o <= 1'b0;
      end
    end
  end

  p_pulse_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid_o |-> (err_flag_o && err_code_o != 4'd0));
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (err_valid_o || !err_flag_o));
  p_late_ref_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid_o && err_code_o == 4'd11) |-> $past(!is_ref));
  p_mrs_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs ##1 !is_quiet |=> err_valid_o);
  p_idle_rw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw && !bopen[ba_i]) |=> err_valid_o);
endmodule

// File: tb/sim_sdram_cmd_monitor.sv
module sim_sdram_cmd_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int REF_LIM = 1562;

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                         C_BST = 4'b0110, C_NOP = 4'b0111, C_DES = 4'b1111,
                         C_DMR = 4'b1000;

  // {cmd, ba, a10, exp_valid, exp_code, exp_bank}
  localparam int N = 38;
  localparam logic [11:0] TBL [N] = '{
    {C_NOP,1'b0,1'b0,1'b0,4'd0,1'b0},   // 0  R1
    {C_DES,1'b0,1'b0,1'b0,4'd0,1'b0},   // 1  R1
    {C_MRS,1'b0,1'b0,1'b0,4'd0,1'b0},   // 2
    {C_DMR,1'b0,1'b0,1'b0,4'd0,1'b0},   // 3  deselect in quiet R1
    {C_REF,1'b0,1'b0,1'b1,4'd2,1'b0},   // 4  R3
    {C_MRS,1'b0,1'b0,1'b0,4'd0,1'b0},   // 5  quiet ended
    {C_NOP,1'b0,1'b0,1'b0,4'd0,1'b0},   // 6
    {C_NOP,1'b0,1'b0,1'b0,4'd0,1'b0},   // 7
    {C_NOP,1'b0,1'b0,1'b0,4'd0,1'b0},   // 8
    {C_ACT,1'b0,1'b0,1'b0,4'd0,1'b0},   // 9
    {C_RD ,1'b0,1'b0,1'b1,4'd5,1'b0},   // 10 R6
    {C_RD ,1'b0,1'b0,1'b0,4'd0,1'b0},   // 11 R6 boundary
    {C_ACT,1'b1,1'b0,1'b0,4'd0,1'b0},   // 12 R8 rrd ok
    {C_ACT,1'b0,1'b0,1'b1,4'd4,1'b0},   // 13 R4 + R12
    {C_PRE,1'b0,1'b0,1'b1,4'd7,1'b0},   // 14 R7 ras
    {C_ACT,1'b0,1'b0,1'b1,4'd6,1'b0},   // 15 R7 rp
    {C_WR ,1'b1,1'b0,1'b0,4'd0,1'b0},   // 16
    {C_MRS,1'b0,1'b0,1'b1,4'd1,1'b0},   // 17 R2
    {C_NOP,1'b0,1'b0,1'b0,4'd0,1'b0},   // 18
    {C_NOP,1'b0,1'b0,1'b0,4'd0,1'b0},   // 19
    {C_PRE,1'b1,1'b1,1'b0,4'd0,1'b0},   // 20 R5 all banks, ras boundary
    {C_RD ,1'b0,1'b0,1'b1,4'd3,1'b0},   // 21 R5/R4
    {C_RD ,1'b1,1'b0,1'b1,4'd3,1'b1},   // 22 R5/R4
    {C_REF,1'b0,1'b0,1'b0,4'd0,1'b0},   // 23
    {C_ACT,1'b1,1'b0,1'b0,4'd0,1'b0},   // 24
    {C_ACT,1'b0,1'b0,1'b1,4'd9,1'b0},   // 25 R8 rrd
    {C_NOP,1'b0,1'b0,1'b0,4'd0,1'b0},   // 26
    {C_RD ,1'b1,1'b1,1'b0,4'd0,1'b0},   // 27 R9 auto-precharge
    {C_WR ,1'b0,1'b0,1'b1,4'd10,1'b0},  // 28 R9
    {C_RD ,1'b1,1'b0,1'b1,4'd10,1'b1},  // 29 R9
    {C_NOP,1'b0,1'b0,1'b0,4'd0,1'b0},   // 30 burst ends
    {C_ACT,1'b1,1'b0,1'b1,4'd6,1'b1},   // 31 R9 closed, rp from burst end
    {C_RD ,1'b0,1'b0,1'b0,4'd0,1'b0},   // 32 R9 window over
    {C_BST,1'b0,1'b0,1'b0,4'd0,1'b0},   // 33 R1
    {C_NOP,1'b0,1'b0,1'b0,4'd0,1'b0},   // 34
    {C_PRE,1'b0,1'b0,1'b0,4'd0,1'b0},   // 35 R5 single bank
    {C_PRE,1'b1,1'b0,1'b0,4'd0,1'b0},   // 36 R7 ras boundary
    {C_NOP,1'b0,1'b0,1'b0,4'd0,1'b0}    // 37
  };

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ba = 1'b0, a10 = 1'b0;
  logic ev, ef, eb;
  logic [3:0] ec;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_monitor #(.REF_LIMIT(REF_LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba_i(ba), .a10_i(a10),
    .err_valid_o(ev), .err_flag_o(ef), .err_code_o(ec), .err_bank_o(eb)
  );

  function automatic string req_of(input logic [3:0] code);
    case (code)
      4'd1: return "R2";  4'd2: return "R3";  4'd3: return "R4";
      4'd4: return "R12"; 4'd5: return "R6";  4'd6: return "R7";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R8";
      4'd10: return "R9"; 4'd11: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic b, input logic a, input logic cl);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b; a10 = a; clr = cl;
    @(negedge clk);
  endtask

  function automatic int obs();
    return {ev, ev ? {ec, eb} : 5'd0};
  endfunction

  initial begin
    int early;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    check("R13", {ev, ef, ec, eb}, 0);

    for (int i = 0; i < N; i++) begin
      drive(TBL[i][11:8], TBL[i][7], TBL[i][6], 1'b0);
      check(TBL[i][5] ? req_of(TBL[i][4:1]) : "R1", obs(),
            {TBL[i][5], TBL[i][5] ? TBL[i][4:0] : 5'd0});
    end

    // R11 last error held, sticky
    drive(C_NOP, 1'b0, 1'b0, 1'b0);
    check("R11", {ev, ef, ec, eb}, {1'b0, 1'b1, 4'd6, 1'b1});
    drive(C_NOP, 1'b0, 1'b0, 1'b1);
    check("R11", {ev, ef, ec, eb}, 0);
    // R11 error beats clear in the same clock
    drive(C_RD, 1'b0, 1'b0, 1'b1);
    check("R11", {ev, ef, ec, eb}, {1'b1, 1'b1, 4'd3, 1'b0});
    drive(C_REF, 1'b0, 1'b0, 1'b1);
    check("R11", {ev, ef}, 0);

    // R10 watchdog: pulse due on the REF_LIM-th idle clock after refresh
    early = 0;
    for (int k = 1; k < REF_LIM; k++) begin
      drive(C_NOP, 1'b0, 1'b0, 1'b0);
      if (ev) early++;
    end
    check("R10", early, 0);
    drive(C_NOP, 1'b0, 1'b0, 1'b0);
    check("R10", {ev, ec, eb}, {1'b1, 4'd11, 1'b0});
    drive(C_NOP, 1'b0, 1'b0, 1'b0);
    check("R10", ev, 0);
    drive(C_REF, 1'b0, 1'b0, 1'b0);
    check("R10", ev, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule